// File: doc/BRIEF.md
# Unconditional Jump Unit with Misaligned-Target Trap

This block executes the two unconditional jump instructions of a 32-bit RISC-V pipeline, JAL and JALR. When its valid strobe is high, it decodes the instruction word and forms the jump target. JAL adds a PC-relative immediate to the current PC. JALR adds a register-relative immediate to the rs1 operand and clears bit 0 of the sum. The block then registers three results for the following cycle: the next program counter, the link write of PC+4 into rd, and the trap writes.

If bit 1 of the computed target is set, the jump is not taken. The block redirects the PC to the trap vector with its two low bits cleared, and it does not perform the rd write. In its place it writes the faulting jump's PC into the exception-PC entry and writes the misaligned-address code into the cause entry.

General registers and trap CSRs share one 6-bit register address space. The block therefore presents the rs1 field and the trap-vector index as read addresses, and it drives every write with a full 6-bit address. Fetch, the register file and all other opcodes belong to neighbouring blocks.

Top module: `jump_unit`

## Requirements
- R1: With opcode 7'b1101111 (JAL) and valid high at a clock edge, next_pc_o after that edge equals pc_i plus the sign-extended J-type immediate {instr[31], instr[19:12], instr[20], instr[30:21], 0}, and next_pc_vld_o is high for exactly that one cycle.
- R2: With opcode 7'b1100111 (JALR) and funct3 instr[14:12] equal to 0, the target is rs1_val_i plus the sign-extended instr[31:20], with bit 0 cleared. rs1_raddr_o carries instr[19:15] zero-extended to 6 bits.
- R3: On a jump whose target has bit 1 clear, rd_we_o pulses for one cycle with rd_waddr_o = instr[11:7] and rd_wdata_o = pc_i + 4.
- R4: When instr[11:7] is 0, no rd write is issued, and the jump itself is still taken.
- R5: When target bit 1 is set, next_pc_o equals tvec_val_i with bits [1:0] forced to 0. tvec_raddr_o is always 6'h25.
- R6: On that trap, epc_we_o and cause_we_o pulse together. The exception-PC write goes to address 6'h29 with data pc_i, and the cause write goes to address 6'h2A with data 0.
- R7: A trapping jump never asserts rd_we_o.
- R8: A cycle with valid low, or with any other opcode (or JALR with nonzero funct3), produces no write enables and no next_pc_vld_o, and next_pc_o keeps its previous value.
- R9: While rst_n is low at a clock edge, all write enables and next_pc_vld_o clear and next_pc_o returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| pc_i | input | 32 | PC of the presented instruction |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | Operand read at rs1_raddr_o |
| rs1_raddr_o | output | 6 | Register-space address of rs1 |
| tvec_raddr_o | output | 6 | Register-space address of the trap vector |
| tvec_val_i | input | 32 | Trap-vector value read at tvec_raddr_o |
| next_pc_o | output | 32 | Redirected program counter |
| next_pc_vld_o | output | 1 | next_pc_o updated this cycle |
| rd_we_o | output | 1 | Link write enable |
| rd_waddr_o | output | 6 | Link write address |
| rd_wdata_o | output | 32 | Link value |
| epc_we_o | output | 1 | Exception-PC write enable |
| epc_waddr_o | output | 6 | Exception-PC address |
| epc_wdata_o | output | 32 | Faulting PC |
| cause_we_o | output | 1 | Cause write enable |
| cause_waddr_o | output | 6 | Cause address |
| cause_wdata_o | output | 32 | Cause code |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 6-bit register space, the trap vector at 0x25, the exception PC at 0x29, the cause register at 0x2A, and cause code 0. These values make the shared-address behaviour visible at the ports, because the bench can compare every write address against these fixed CSR slots. A 32-bit datapath also lets negative immediates wrap the target across zero, and it lets targets with bit 1 set come from both the PC-relative and the register-relative forms.

// File: rtl/jmp_pkg.sv
// Package: shared opcode constants and the decoded-jump record.
// Assumes 32-bit instruction words in the base RISC-V encoding.
package jmp_pkg;
    localparam logic [6:0] OPC_JAL  = 7'b1101111;
    localparam logic [6:0] OPC_JALR = 7'b1100111;

    typedef enum logic [1:0] {
        JK_NONE = 2'd0,
        JK_JAL  = 2'd1,
        JK_JALR = 2'd2
    } jump_kind_e;

    typedef struct packed {
        jump_kind_e  kind;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [31:0] imm;
    } jmp_dec_t;
endpackage

// File: rtl/jmp_decode.sv
// Module: jmp_decode
// Classifies an instruction word as JAL, JALR or neither, and extracts
// rd, rs1 and the sign-extended immediate for the matching form.
// Assumes the instruction word is stable for the whole cycle; purely combinational.
module jmp_decode
    import jmp_pkg::*;
(
    input  logic [31:0] instr,
    output jmp_dec_t    dec
);
    logic [31:0] imm_j;
    logic [31:0] imm_i;

    // Build both immediate forms from the instruction fields
    always_comb begin
        imm_j = {{12{instr[31]}}, instr[19:12], instr[20], instr[30:21], 1'b0};
        imm_i = {{20{instr[31]}}, instr[31:20]};
    end

    // Select the kind and the immediate that goes with it
    always_comb begin
        dec.rd  = instr[11:7];
        dec.rs1 = instr[19:15];
        if (instr[6:0] == OPC_JAL) begin
            dec.kind = JK_JAL;
            dec.imm  = imm_j;
        end else if (instr[6:0] == OPC_JALR && instr[14:12] == 3'b000) begin
            dec.kind = JK_JALR;
            dec.imm  = imm_i;
        end else begin
            dec.kind = JK_NONE;
            dec.imm  = '0;
        end
    end
endmodule

// File: rtl/jmp_target.sv
// Module: jmp_target
// Forms the jump target, the link value and the misalignment flag.
// Assumes a 32-bit-aligned instruction stream, so link is always PC+4.
module jmp_target
    import jmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  jump_kind_e      kind,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] link,
    output logic            misalign
);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] sum;

    // Pick the base operand and add the immediate
    always_comb begin
        base = (kind == JK_JALR) ? rs1_val : pc;
        sum  = base + imm;
    end

    // Clear bit 0 for the register-relative form, then flag bit 1
    always_comb begin
        target = sum;
        if (kind == JK_JALR) target[0] = 1'b0;
        misalign = target[1];
        link     = pc + INSN_BYTES;
    end
endmodule

// File: rtl/jmp_commit.sv
// Module: jmp_commit
// Registers the one-cycle results of a jump: PC redirect, link write,
// or trap writes. Assumes a synchronous active-low reset.
module jmp_commit
    import jmp_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              misalign,
    input  logic [XLEN-1:0]   target,
    input  logic [XLEN-1:0]   link,
    input  logic [4:0]        rd,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   tvec,
    output logic [XLEN-1:0]   next_pc,
    output logic              next_pc_vld,
    output logic              rd_we,
    output logic [REG_AW-1:0] rd_waddr,
    output logic [XLEN-1:0]   rd_wdata,
    output logic              trap_we,
    output logic [XLEN-1:0]   trap_pc
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    // Sequence the registered outputs for each accepted jump
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc     <= '0;
            next_pc_vld <= 1'b0;
            rd_we       <= 1'b0;
            rd_waddr    <= '0;
            rd_wdata    <= '0;
            trap_we     <= 1'b0;
            trap_pc     <= '0;
        end else begin
            next_pc_vld <= fire;
            rd_we       <= fire && !misalign && (rd != 5'd0);
            trap_we     <= fire && misalign;
            if (fire) begin
                next_pc  <= misalign ? (tvec & ALIGN_MASK) : target;
                rd_waddr <= REG_AW'(rd);
                rd_wdata <= link;
                trap_pc  <= pc;
            end
        end
    end

    AST_TRAP_BLOCKS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        trap_we |-> !rd_we); // R7
    AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> rd_waddr != '0); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (!rd_we && !trap_we && !next_pc_vld)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(next_pc)); // R8
    AST_TRAP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        trap_we |-> next_pc[1:0] == 2'b00); // R5
endmodule

// File: rtl/jump_unit.sv
// Module: jump_unit
// Executes JAL/JALR: redirects the PC, writes the link register, or
// traps on a target with bit 1 set by writing exception-PC and cause
// into the shared 64-entry register space. Assumes one instruction per
// valid strobe and a synchronous active-low reset.
module jump_unit
    import jmp_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter int               REG_AW     = 6,
    parameter logic [REG_AW-1:0] TVEC_IDX  = 6'h25,
    parameter logic [REG_AW-1:0] EPC_IDX   = 6'h29,
    parameter logic [REG_AW-1:0] CAUSE_IDX = 6'h2A,
    parameter logic [XLEN-1:0]  CAUSE_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [31:0]       instr_i,
    input  logic [XLEN-1:0]   rs1_val_i,
    output logic [REG_AW-1:0] rs1_raddr_o,
    output logic [REG_AW-1:0] tvec_raddr_o,
    input  logic [XLEN-1:0]   tvec_val_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              next_pc_vld_o,
    output logic              rd_we_o,
    output logic [REG_AW-1:0] rd_waddr_o,
    output logic [XLEN-1:0]   rd_wdata_o,
    output logic              epc_we_o,
    output logic [REG_AW-1:0] epc_waddr_o,
    output logic [XLEN-1:0]   epc_wdata_o,
    output logic              cause_we_o,
    output logic [REG_AW-1:0] cause_waddr_o,
    output logic [XLEN-1:0]   cause_wdata_o
);
    jmp_dec_t        dec;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] link;
    logic            misalign;
    logic            fire;
    logic            trap_we;

    jmp_decode u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    jmp_target #(.XLEN(XLEN)) u_tgt (
        .kind     (dec.kind),
        .pc       (pc_i),
        .rs1_val  (rs1_val_i),
        .imm      (XLEN'(dec.imm)),
        .target   (target),
        .link     (link),
        .misalign (misalign)
    );

    // Accept only a valid jump opcode
    always_comb fire = valid_i && (dec.kind != JK_NONE);

    jmp_commit #(.XLEN(XLEN), .REG_AW(REG_AW)) u_cmt (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .misalign    (misalign),
        .target      (target),
        .link        (link),
        .rd          (dec.rd),
        .pc          (pc_i),
        .tvec        (tvec_val_i),
        .next_pc     (next_pc_o),
        .next_pc_vld (next_pc_vld_o),
        .rd_we       (rd_we_o),
        .rd_waddr    (rd_waddr_o),
        .rd_wdata    (rd_wdata_o),
        .trap_we     (trap_we),
        .trap_pc     (epc_wdata_o)
    );

    // Fixed register-space addresses and trap write fan-out
    always_comb begin
        rs1_raddr_o   = REG_AW'(dec.rs1);
        tvec_raddr_o  = TVEC_IDX;
        epc_waddr_o   = EPC_IDX;
        cause_waddr_o = CAUSE_IDX;
        cause_wdata_o = CAUSE_CODE;
        epc_we_o      = trap_we;
        cause_we_o    = trap_we;
    end

    AST_EPC_IS_FAULT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && misalign) |=> (epc_we_o && epc_wdata_o == $past(pc_i))); // R6
    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> next_pc_vld_o); // R3
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!rd_we_o && !epc_we_o && !cause_we_o && !next_pc_vld_o)); // R9
endmodule

// File: tb/tb_jump_unit.sv
module tb_jump_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] pc_i = '0, instr_i = '0, rs1_val_i = '0, tvec_val_i = '0;
    logic [5:0]  rs1_raddr_o, tvec_raddr_o, rd_waddr_o, epc_waddr_o, cause_waddr_o;
    logic [31:0] next_pc_o, rd_wdata_o, epc_wdata_o, cause_wdata_o;
    logic        next_pc_vld_o, rd_we_o, epc_we_o, cause_we_o;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk; // 125 MHz

    jump_unit dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pc_i(pc_i),
        .instr_i(instr_i), .rs1_val_i(rs1_val_i), .rs1_raddr_o(rs1_raddr_o),
        .tvec_raddr_o(tvec_raddr_o), .tvec_val_i(tvec_val_i),
        .next_pc_o(next_pc_o), .next_pc_vld_o(next_pc_vld_o),
        .rd_we_o(rd_we_o), .rd_waddr_o(rd_waddr_o), .rd_wdata_o(rd_wdata_o),
        .epc_we_o(epc_we_o), .epc_waddr_o(epc_waddr_o), .epc_wdata_o(epc_wdata_o),
        .cause_we_o(cause_we_o), .cause_waddr_o(cause_waddr_o),
        .cause_wdata_o(cause_wdata_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_jal(input logic [20:0] imm, input logic [4:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_jalr(input logic [11:0] imm, input logic [4:0] rs1,
                                             input logic [4:0] rd);
        return {imm, rs1, 3'b000, rd, 7'b1100111};
    endfunction

    // Present one instruction for one cycle; return at the sampling point after the edge
    task automatic issue(input logic [31:0] pc, input logic [31:0] ins,
                         input logic [31:0] rs1v, input logic [31:0] tv);
        pc_i = pc; instr_i = ins; rs1_val_i = rs1v; tvec_val_i = tv; valid_i = 1'b1;
        #1;
        chk("R2 rs1_raddr", {26'd0, rs1_raddr_o}, {27'd0, ins[19:15]});
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic expect_jump(input string tag, input logic [31:0] tgt, input logic [4:0] rd,
                               input logic [31:0] pc);
        chk({tag, " next_pc"}, next_pc_o, tgt);
        chk({tag, " vld"}, {31'd0, next_pc_vld_o}, 32'd1);
        chk({tag, " R7 no trap"}, {31'd0, epc_we_o | cause_we_o}, 32'd0);
        if (rd != 0) begin
            chk({tag, " R3 rd_we"}, {31'd0, rd_we_o}, 32'd1);
            chk({tag, " R3 rd_waddr"}, {26'd0, rd_waddr_o}, {27'd0, rd});
            chk({tag, " R3 rd_wdata"}, rd_wdata_o, pc + 32'd4);
        end else begin
            chk({tag, " R4 no rd write"}, {31'd0, rd_we_o}, 32'd0);
        end
    endtask

    task automatic expect_trap(input string tag, input logic [31:0] tv, input logic [31:0] pc);
        chk({tag, " R5 next_pc"}, next_pc_o, tv & ~32'd3);
        chk({tag, " R5 tvec addr"}, {26'd0, tvec_raddr_o}, 32'h25);
        chk({tag, " R7 no rd"}, {31'd0, rd_we_o}, 32'd0);
        chk({tag, " R6 epc_we"}, {31'd0, epc_we_o}, 32'd1);
        chk({tag, " R6 epc addr"}, {26'd0, epc_waddr_o}, 32'h29);
        chk({tag, " R6 epc data"}, epc_wdata_o, pc);
        chk({tag, " R6 cause_we"}, {31'd0, cause_we_o}, 32'd1);
        chk({tag, " R6 cause addr"}, {26'd0, cause_waddr_o}, 32'h2A);
        chk({tag, " R6 cause data"}, cause_wdata_o, 32'd0);
    endtask

    // One cycle later everything must be quiet and the PC held
    task automatic expect_quiet(input string tag, input logic [31:0] held);
        @(negedge clk);
        chk({tag, " R8 quiet"}, {29'd0, rd_we_o, epc_we_o, cause_we_o}, 32'd0);
        chk({tag, " R8/R1 vld drop"}, {31'd0, next_pc_vld_o}, 32'd0);
        chk({tag, " R8 pc held"}, next_pc_o, held);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 vld", {31'd0, next_pc_vld_o}, 32'd0);
        chk("R9 enables", {29'd0, rd_we_o, epc_we_o, cause_we_o}, 32'd0);
        chk("R9 next_pc", next_pc_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_jal_fwd();
        issue(32'h0000_1000, enc_jal(21'h00100, 5'd1), 32'h0, 32'h0);
        expect_jump("R1 jal fwd", 32'h0000_1100, 5'd1, 32'h0000_1000);
        expect_quiet("R1 jal fwd", 32'h0000_1100);
    endtask

    task automatic t_jal_back();
        issue(32'h0000_2000, enc_jal(21'h1FF000, 5'd5), 32'h0, 32'h0); // -4096
        expect_jump("R1 jal back", 32'h0000_1000, 5'd5, 32'h0000_2000);
    endtask

    task automatic t_jalr();
        issue(32'h0000_0400, enc_jalr(12'hFF8, 5'd7, 5'd9), 32'h0000_8010, 32'h0); // -8
        expect_jump("R2 jalr", 32'h0000_8008, 5'd9, 32'h0000_0400);
    endtask

    task automatic t_jalr_bit0();
        issue(32'h0000_0500, enc_jalr(12'h005, 5'd3, 5'd31), 32'h0000_3000, 32'h0);
        expect_jump("R2 jalr bit0", 32'h0000_3004, 5'd31, 32'h0000_0500);
    endtask

    task automatic t_rd_zero();
        issue(32'h0000_0800, enc_jal(21'h00020, 5'd0), 32'h0, 32'h0);
        expect_jump("R4 rd0", 32'h0000_0820, 5'd0, 32'h0000_0800);
    endtask

    task automatic t_trap_jal();
        issue(32'h0000_0100, enc_jal(21'h00006, 5'd4), 32'h0, 32'hDEAD_BEEF);
        expect_trap("R5 jal trap", 32'hDEAD_BEEF, 32'h0000_0100);
        expect_quiet("R5 jal trap", 32'hDEAD_BEEC);
    endtask

    task automatic t_trap_jalr();
        issue(32'h0000_0200, enc_jalr(12'h002, 5'd6, 5'd8), 32'h0000_4000, 32'h0000_7003);
        expect_trap("R6 jalr trap", 32'h0000_7003, 32'h0000_0200);
    endtask

    task automatic t_ignored();
        issue(32'h0000_0300, enc_jal(21'h00040, 5'd2), 32'h0, 32'h0);
        expect_jump("R8 setup", 32'h0000_0340, 5'd2, 32'h0000_0300);
        issue(32'h0000_0900, 32'h0020_80B3, 32'h0000_5000, 32'h0); // ALU op, rd=1
        chk("R8 other opcode vld", {31'd0, next_pc_vld_o}, 32'd0);
        chk("R8 other opcode we", {29'd0, rd_we_o, epc_we_o, cause_we_o}, 32'd0);
        chk("R8 other opcode pc", next_pc_o, 32'h0000_0340);
        issue(32'h0000_0A00, enc_jalr(12'h010, 5'd1, 5'd1) | 32'h0000_1000, 32'h100, 32'h0);
        chk("R8 jalr funct3", {30'd0, next_pc_vld_o, rd_we_o}, 32'd0);
        chk("R8 jalr funct3 pc", next_pc_o, 32'h0000_0340);
        pc_i = 32'h0000_0B00; instr_i = enc_jal(21'h00010, 5'd3);
        expect_quiet("R8 valid low", 32'h0000_0340);
    endtask

    initial begin
        t_reset();
        t_jal_fwd();
        t_jal_back();
        t_jalr();
        t_jalr_bit0();
        t_rd_zero();
        t_trap_jal();
        t_trap_jalr();
        t_ignored();
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule